// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block gives an external debugger two scan chains for running instructions on a core and moving words to and from it. The instruction chain carries a 32-bit instruction toward the core. On the way out it reports whether the last issued instruction has finished. The data chain carries one 32-bit word in either direction per scan. Each data scan also returns two status bits, so the host can tell on every scan whether the access took effect.

All strobes (capture, shift, update) and the Run-Test/Idle level come from a TAP controller, sampled on the test clock `clk`. The chain in use is chosen by `chain_sel`, and the access mode by `ir_mode`. The core is started by a one-cycle `core_issue` pulse. This pulse is produced only when the TAP newly enters Run-Test/Idle while an execution-capable chain and mode are selected. A host can therefore end a scan in Pause-DR, load the data chain, and only then pass through idle to start the instruction.

Top module: `dxc_chains`

## Requirements
- R1: The instruction chain is 33 bits, shifted least significant bit first. Bits 0..31 are the instruction and bit 32 is the completion flag. Capture loads the current instruction and the flag.
- R2: An update while `chain_sel` = 4 and `ir_mode` is read (2'b01) or write (2'b10) loads bits 0..31 of the instruction chain into `core_instr`.
- R3: `core_issue` pulses high for one cycle, one cycle after the first cycle in which `tap_idle` is sampled high following a low sample. This happens only when `chain_sel` is 4 or 5 and `ir_mode` is 2'b01 or 2'b10.
- R4: Staying in idle for further cycles gives no further pulse. Entering idle with another chain (for example 0) or with `ir_mode` 2'b00 gives no pulse.
- R5: The completion flag reads 1 after reset. An issue clears it, and a `core_done` pulse sets it again.
- R6: The data chain is 34 bits, shifted least significant bit first. Bits 0..31 are data, bit 32 is Ready and bit 33 is the retry bit. It is used when `chain_sel` = 5.
- R7: A write scan (`ir_mode` 2'b10) captures Ready = retry = 1 if no word is waiting for the core, and 0 otherwise. The captured data bits are 0. On update, a Ready write stores the shifted word in `to_core_data` and raises `to_core_valid`. A write that was not Ready is dropped and leaves `to_core_data` unchanged.
- R8: A read scan (`ir_mode` 2'b01) captures the core's last word with Ready = retry = 1 and marks that word consumed. If no word is pending, it captures data 0 with Ready = retry = 0.
- R9: `core_take` clears `to_core_valid`. `core_wr` stores `core_wdata` as the pending word for the next read scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_idle | input | 1 | TAP is in Run-Test/Idle |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| chain_sel | input | 4 | Selected scan chain number |
| ir_mode | input | 2 | 01 read, 10 write, other: no access |
| tdo | output | 1 | Serial data out of the selected chain |
| core_issue | output | 1 | One-cycle execute pulse to the core |
| core_instr | output | 32 | Instruction to execute |
| core_done | input | 1 | Core finished the issued instruction |
| core_take | input | 1 | Core consumed the word sent to it |
| core_wr | input | 1 | Core writes a word toward the host |
| core_wdata | input | 32 | Word written by the core |
| to_core_valid | output | 1 | A word waits for the core |
| to_core_data | output | 32 | Word for the core |

## Verification
A stuck or stale completion flag shows in bit 32 of the next instruction-chain capture. The idle-edge register shows as extra or missing `core_issue` pulses within two cycles of idle entry. A wrong pending-word state in the data chain shows in the Ready and retry bits of the very next data scan. It also shows as `to_core_data` changing after a write that reported not-Ready. A lost core word shows as data 0 with Ready 0 on the following read scan.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [1:0] {
    IR_NONE  = 2'b00,
    IR_READ  = 2'b01,
    IR_WRITE = 2'b10,
    IR_SPARE = 2'b11
  } ir_mode_e;
endpackage

// File: rtl/dxc_issue_gen.sv
module dxc_issue_gen #(
  parameter int SEL_W    = 4,
  parameter int INSTR_ID = 4,
  parameter int DATA_ID  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tap_idle,
  input  logic [SEL_W-1:0] chain_sel,
  input  logic [1:0]       ir_mode,
  output logic             issue_now,
  output logic             core_issue
);
  import dxc_pkg::*;

  logic idle_q;
  logic run_ok;

  assign run_ok = ((chain_sel == SEL_W'(INSTR_ID)) || (chain_sel == SEL_W'(DATA_ID))) &&
                  ((ir_mode == IR_READ) || (ir_mode == IR_WRITE));
  assign issue_now = tap_idle && !idle_q && run_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q     <= 1'b0;
      core_issue <= 1'b0;
    end else begin
      idle_q     <= tap_idle;
      core_issue <= issue_now;
    end
  end

  // R4
  no_reissue_chk: assert property (@(posedge clk) disable iff (rst)
    core_issue |=> !core_issue);
  // R3
  issue_idle_chk: assert property (@(posedge clk) disable iff (rst)
    core_issue |-> $past(tap_idle));
endmodule

// File: rtl/dxc_instr_chain.sv
module dxc_instr_chain #(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               capture,
  input  logic               shift,
  input  logic               update,
  input  logic               tdi,
  input  logic               issue_now,
  input  logic               core_done,
  output logic               tdo,
  output logic [INSTR_W-1:0] core_instr
);
  localparam int LEN = INSTR_W + 1;

  logic [LEN-1:0] sr;
  logic           done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      core_instr <= '0;
    end else if (active) begin
      if (capture)
        sr <= {done_q, core_instr};
      else if (shift)
        sr <= {tdi, sr[LEN-1:1]};
      else if (update)
        core_instr <= sr[INSTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      done_q <= 1'b1;
    else if (issue_now)
      done_q <= 1'b0;
    else if (core_done)
      done_q <= 1'b1;
  end

  assign tdo = sr[0];

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    issue_now |=> !done_q);
endmodule

// File: rtl/dxc_data_chain.sv
module dxc_data_chain #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              mode_rd,
  input  logic              mode_wr,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  input  logic              core_take,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              tdo,
  output logic              to_core_valid,
  output logic [DATA_W-1:0] to_core_data
);
  localparam int LEN = DATA_W + 2;

  logic [LEN-1:0]    sr;
  logic              cap_ok;
  logic              from_valid;
  logic [DATA_W-1:0] from_word;
  logic              wr_free;
  logic              do_cap_rd;

  assign wr_free   = !to_core_valid || core_take;
  assign do_cap_rd = active && capture && mode_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cap_ok <= 1'b0;
    end else if (active) begin
      if (capture) begin
        if (mode_wr) begin
          sr     <= {wr_free, wr_free, {DATA_W{1'b0}}};
          cap_ok <= wr_free;
        end else begin
          sr     <= {from_valid, from_valid, (from_valid ? from_word : {DATA_W{1'b0}})};
          cap_ok <= 1'b0;
        end
      end else if (shift) begin
        sr <= {tdi, sr[LEN-1:1]};
      end else if (update) begin
        cap_ok <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_core_valid <= 1'b0;
      to_core_data  <= '0;
    end else if (active && update && mode_wr && cap_ok) begin
      to_core_valid <= 1'b1;
      to_core_data  <= sr[DATA_W-1:0];
    end else if (core_take) begin
      to_core_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      from_valid <= 1'b0;
      from_word  <= '0;
    end else if (core_wr) begin
      from_valid <= 1'b1;
      from_word  <= core_wdata;
    end else if (do_cap_rd) begin
      from_valid <= 1'b0;
    end
  end

  assign tdo = sr[0];

  // R7
  drop_write_chk: assert property (@(posedge clk) disable iff (rst)
    (active && update && mode_wr && !cap_ok) |=> $stable(to_core_data));
  // R8
  read_consume_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(from_valid) |-> $past(do_cap_rd));
endmodule

// File: rtl/dxc_chains.sv
module dxc_chains #(
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 4,
  parameter int INSTR_ID = 4,
  parameter int DATA_ID  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tap_idle,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [SEL_W-1:0]  chain_sel,
  input  logic [1:0]        ir_mode,
  output logic              tdo,
  output logic              core_issue,
  output logic [DATA_W-1:0] core_instr,
  input  logic              core_done,
  input  logic              core_take,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              to_core_valid,
  output logic [DATA_W-1:0] to_core_data
);
  import dxc_pkg::*;

  logic mode_rd, mode_wr, acc_ok;
  logic sel_instr, sel_data;
  logic issue_now;
  logic i_tdo, d_tdo;

  assign mode_rd   = (ir_mode == IR_READ);
  assign mode_wr   = (ir_mode == IR_WRITE);
  assign acc_ok    = mode_rd || mode_wr;
  assign sel_instr = acc_ok && (chain_sel == SEL_W'(INSTR_ID));
  assign sel_data  = acc_ok && (chain_sel == SEL_W'(DATA_ID));

  dxc_issue_gen #(.SEL_W(SEL_W), .INSTR_ID(INSTR_ID), .DATA_ID(DATA_ID)) u_issue (
    .clk(clk), .rst(rst), .tap_idle(tap_idle), .chain_sel(chain_sel),
    .ir_mode(ir_mode), .issue_now(issue_now), .core_issue(core_issue)
  );

  dxc_instr_chain #(.INSTR_W(DATA_W)) u_instr (
    .clk(clk), .rst(rst), .active(sel_instr), .capture(capture_dr),
    .shift(shift_dr), .update(update_dr), .tdi(tdi), .issue_now(issue_now),
    .core_done(core_done), .tdo(i_tdo), .core_instr(core_instr)
  );

  dxc_data_chain #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .active(sel_data), .mode_rd(mode_rd), .mode_wr(mode_wr),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
    .core_take(core_take), .core_wr(core_wr), .core_wdata(core_wdata),
    .tdo(d_tdo), .to_core_valid(to_core_valid), .to_core_data(to_core_data)
  );

  assign tdo = sel_data ? d_tdo : (sel_instr ? i_tdo : 1'b0);
endmodule

// File: tb/dxc_chains_test.sv
module dxc_chains_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tap_idle = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic [3:0]  chain_sel = 4'd0;
  logic [1:0]  ir_mode = 2'b00;
  logic        tdo, core_issue, to_core_valid;
  logic [31:0] core_instr, to_core_data;
  logic        core_done = 1'b0, core_take = 1'b0, core_wr = 1'b0;
  logic [31:0] core_wdata = '0;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  localparam logic [63:0] VEC [4] = '{
    {32'h1234_5678, 32'hCAFE_0001},
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'h8000_0001, 32'h5A5A_A5A5}
  };

  always #2 clk = ~clk;

  dxc_chains uut (
    .clk(clk), .rst(rst), .tap_idle(tap_idle), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .chain_sel(chain_sel),
    .ir_mode(ir_mode), .tdo(tdo), .core_issue(core_issue), .core_instr(core_instr),
    .core_done(core_done), .core_take(core_take), .core_wr(core_wr),
    .core_wdata(core_wdata), .to_core_valid(to_core_valid), .to_core_data(to_core_data)
  );

  always @(posedge clk) if (!rst && core_issue) pulses <= pulses + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic scan(input logic [33:0] din, input int n, output logic [33:0] dout);
    dout = '0;
    capture_dr = 1'b1;
    @(posedge clk); @(negedge clk);
    capture_dr = 1'b0;
    shift_dr   = 1'b1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      @(posedge clk); @(negedge clk);
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(posedge clk); @(negedge clk);
    update_dr = 1'b0;
  endtask

  task automatic idle_visit(input int k);
    tap_idle = 1'b1;
    repeat (k) begin @(posedge clk); @(negedge clk); end
    tap_idle = 1'b0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse_core(input int which, input logic [31:0] w);
    if (which == 0) core_done = 1'b1;
    else if (which == 1) core_take = 1'b1;
    else begin core_wr = 1'b1; core_wdata = w; end
    @(posedge clk); @(negedge clk);
    core_done = 1'b0; core_take = 1'b0; core_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [33:0] so;
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(core_issue == 1'b0 && to_core_valid == 1'b0, "reset R3 R7", {core_issue, to_core_valid}, 0);

    // R1 R2: instruction scan, capture after reset shows flag 1, instr 0
    chain_sel = 4'd4; ir_mode = 2'b10;
    scan({2'b00, 32'hE1A0_0000}, 33, so);
    chk(so[32:0] == {1'b1, 32'h0}, "R1 capture", so, {1'b1, 32'h0});
    chk(core_instr == 32'hE1A0_0000, "R2 update", core_instr, 32'hE1A0_0000);

    // R3 R4: one pulse across several idle cycles
    p0 = pulses;
    idle_visit(4);
    chk(pulses - p0 == 1, "R3 R4 single issue", pulses - p0, 1);

    // R5: flag cleared by issue, then set by core_done
    scan({2'b00, 32'hE1A0_0000}, 33, so);
    chk(so[32] == 1'b0, "R5 flag cleared", so[32], 0);
    pulse_core(0, 0);
    scan({2'b00, 32'hE1A0_0000}, 33, so);
    chk(so[32] == 1'b1 && so[31:0] == 32'hE1A0_0000, "R5 R1 flag set", so[32:0], {1'b1, 32'hE1A0_0000});

    // R4: no issue with other chain or no-access mode
    chain_sel = 4'd0; p0 = pulses;
    idle_visit(2);
    chk(pulses == p0, "R4 chain 0", pulses - p0, 0);
    chain_sel = 4'd5; ir_mode = 2'b00;
    idle_visit(2);
    chk(pulses == p0, "R4 mode none", pulses - p0, 0);
    ir_mode = 2'b01;
    idle_visit(2);
    chk(pulses - p0 == 1, "R3 data chain read", pulses - p0, 1);

    // R8: read with nothing pending
    scan(34'h0, 34, so);
    chk(so == 34'h0, "R8 empty read", so, 0);

    // R6 R7 R8 R9: vector table walk
    for (int v = 0; v < 4; v++) begin
      ir_mode = 2'b10;
      scan({2'b00, VEC[v][63:32]}, 34, so);
      chk(so[33:32] == 2'b11 && so[31:0] == 32'h0, "R6 R7 write ready", so, {2'b11, 32'h0});
      chk(to_core_valid && to_core_data == VEC[v][63:32], "R7 word stored", to_core_data, VEC[v][63:32]);
      pulse_core(1, 0);
      chk(!to_core_valid, "R9 take clears", to_core_valid, 0);
      pulse_core(2, VEC[v][31:0]);
      ir_mode = 2'b01;
      scan(34'h0, 34, so);
      chk(so == {2'b11, VEC[v][31:0]}, "R6 R8 read word", so, {2'b11, VEC[v][31:0]});
    end

    // R8: word consumed by previous read
    scan(34'h0, 34, so);
    chk(so == 34'h0, "R8 consumed", so, 0);

    // R7: second write while word pending is dropped
    ir_mode = 2'b10;
    scan({2'b00, 32'hAAAA_0001}, 34, so);
    scan({2'b00, 32'hBBBB_0002}, 34, so);
    chk(so[33:32] == 2'b00, "R7 not ready", so[33:32], 0);
    chk(to_core_data == 32'hAAAA_0001, "R7 drop keeps word", to_core_data, 32'hAAAA_0001);
    pulse_core(1, 0);
    scan({2'b00, 32'hBBBB_0002}, 34, so);
    chk(so[33:32] == 2'b11 && to_core_data == 32'hBBBB_0002, "R7 R9 ready again", to_core_data, 32'hBBBB_0002);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule